// File: doc/BRIEF.md
# Tear-proof buffered write sequencer

This block sits between a command decoder and a byte-wide nonvolatile memory. It turns each write request into a series of single-byte memory cycles. Each cycle is one issue clock followed by a fixed number of wait clocks, which stands in for the self-timed programming time. With tear protection off, the request bytes go straight to the destination.

With tear protection on, the request is first staged in a reserved record inside the same memory. The record holds the payload, the byte count, the destination address and a commit marker, and the marker is written last. Only then are the destination bytes written, and the marker is cleared at the very end. After any restart the block reads the marker. If it is set, the block reloads the record and replays the destination write before it accepts new work, so a write cut by power loss is always completed.

The busy output is high whenever the block is not idle. The serial front end uses it to refuse acknowledgement of polls, so the host learns by polling when a write or a replay has finished.

Top module: `tear_guard_writer`

## Requirements
- R1: After reset, if the byte at the record base (offset 0) does not equal 0xA5, the block becomes idle (busy low) at the first clock after reset release and issues no memory write.
- R2: With tear protection on, writes are issued in this order: payload bytes to record offsets 4 and up, the count to offset 1, the address low byte to offset 2, the address high byte (zero-extended) to offset 3, the marker 0xA5 to offset 0, then the destination bytes in ascending order, then 0x00 to offset 0.
- R3: Each memory write is a single cycle with `nvm_we` high, followed by WR_CYCLES cycles without a write. Busy stays high from the cycle after acceptance until the last wait cycle, and `nvm_we` is never high while the block is idle.
- R4: With tear protection off, a request of 1 to MAXB bytes writes only the destination bytes, in ascending address order, and touches no other location.
- R5: A request whose length is 0, or above 8 with tear protection on, or above MAXB with it off, pulses `req_err` for one cycle. Nothing is written and busy stays low.
- R6: A request presented while busy is high is ignored. It causes no error and no write.
- R7: In a cycle where `pwr_fail` is high, `nvm_we` is low. From the next cycle until reset the block issues no write and holds busy high.
- R8: When the marker is 0xA5 at reset release, the block spends 3+count cycles reading the record at offsets 1 to 3+count. It then writes the count bytes to the recorded address and then 0x00 to offset 0, with busy high throughout.
- R9: After power fails at any cycle of a protected write and the block restarts, the destination holds either all of its old bytes or all of the new ones, and it holds the new ones whenever the marker write had completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, the power-up event |
| pwr_fail | input | 1 | Supply loss; aborts all activity until reset |
| at_enable | input | 1 | Tear protection on for the request |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | Destination start address |
| req_len | input | LEN_W | Number of bytes in the request |
| req_data | input | MAXB*8 | Payload, byte i in bits 8i+7..8i |
| busy | output | 1 | Block not idle; polls must be refused |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| nvm_we | output | 1 | Memory byte write strobe |
| nvm_addr | output | ADDR_W | Memory address for a write or a read |
| nvm_wdata | output | 8 | Memory write byte |
| nvm_rdata | input | 8 | Memory read byte for `nvm_addr`, combinational |

## Verification
Power loss and a write issue cycle can fall in the same clock. The outcome then depends on whether the gated write was the marker set, the marker clear or a destination byte. The bench runs a protected six-byte write and raises `pwr_fail` at every cycle offset from the first issue to past the end, which includes the exact issue cycles of both marker writes. After each cut it restarts the block and compares the replay cycle by cycle against its model. It then judges the destination as all old or all new, deciding which from how many writes had completed before the cut.

// File: rtl/atw_pkg.sv
package atw_pkg;

  typedef enum logic [2:0] {
    ST_PEEK,
    ST_LOAD,
    ST_IDLE,
    ST_STAGE,
    ST_COMMIT,
    ST_RETIRE,
    ST_DEAD
  } atw_state_e;

  localparam logic [7:0] MARK_SET = 8'hA5;
  localparam logic [7:0] MARK_CLR = 8'h00;

  localparam int OFS_MARK = 0;
  localparam int OFS_LEN  = 1;
  localparam int OFS_ALO  = 2;
  localparam int OFS_AHI  = 3;
  localparam int OFS_DATA = 4;

  // record offset for staging step idx of a len-byte request
  function automatic int stage_offset(int idx, int len);
    if (idx < len)          return OFS_DATA + idx;
    else if (idx == len)    return OFS_LEN;
    else if (idx == len + 1) return OFS_ALO;
    else if (idx == len + 2) return OFS_AHI;
    else                    return OFS_MARK;
  endfunction

  function automatic logic [7:0] stage_byte(int idx, int len, logic [7:0] payload,
                                            logic [15:0] dst);
    if (idx < len)           return payload;
    else if (idx == len)     return 8'(len);
    else if (idx == len + 1) return dst[7:0];
    else if (idx == len + 2) return dst[15:8];
    else                     return MARK_SET;
  endfunction

  function automatic logic len_ok(int len, logic guarded, int guard_max, int plain_max);
    return (len != 0) && (len <= (guarded ? guard_max : plain_max));
  endfunction

endpackage

// File: rtl/atw_cycle_timer.sv
module atw_cycle_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/atw_write_plan.sv
module atw_write_plan
  import atw_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int MAXB     = 16,
  parameter int LEN_W    = 5,
  parameter int IDX_W    = 5,
  parameter int BUF_BASE = 1008
) (
  input  atw_state_e        st,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] dst,
  input  logic [MAXB*8-1:0] data,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        wdata,
  output logic              last
);
  int         i_int;
  int         l_int;
  logic [7:0] cur_byte;

  always_comb begin
    i_int    = int'(idx);
    l_int    = int'(len);
    cur_byte = (i_int < MAXB) ? data[i_int*8 +: 8] : 8'h00;
    addr     = ADDR_W'(BUF_BASE);
    wdata    = MARK_CLR;
    last     = 1'b0;
    case (st)
      ST_STAGE: begin
        addr  = ADDR_W'(BUF_BASE + stage_offset(i_int, l_int));
        wdata = stage_byte(i_int, l_int, cur_byte, 16'(dst));
        last  = (i_int == l_int + 3);
      end
      ST_COMMIT: begin
        addr  = dst + ADDR_W'(idx);
        wdata = cur_byte;
        last  = (i_int == l_int - 1);
      end
      ST_RETIRE: begin
        addr = ADDR_W'(BUF_BASE + OFS_MARK);
        last = 1'b1;
      end
      ST_LOAD:  addr = ADDR_W'(BUF_BASE + OFS_LEN + i_int);
      default:  addr = ADDR_W'(BUF_BASE + OFS_MARK);
    endcase
  end
endmodule

// File: rtl/tear_guard_writer.sv
module tear_guard_writer
  import atw_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MAXB      = 16,
  parameter int AT_MAXB   = 8,
  parameter int WR_CYCLES = 4,
  parameter int BUF_BASE  = 1008,
  parameter int LEN_W     = $clog2(MAXB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic              at_enable,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [MAXB*8-1:0] req_data,
  output logic              busy,
  output logic              req_err,
  output logic              nvm_we,
  output logic [ADDR_W-1:0] nvm_addr,
  output logic [7:0]        nvm_wdata,
  input  logic [7:0]        nvm_rdata
);
  localparam int IDX_W = $clog2(MAXB + 4);

  atw_state_e        st;
  logic [IDX_W-1:0]  idx;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [MAXB*8-1:0] data_q;
  logic              at_q;
  logic              wait_q;
  logic              err_q;

  // named events for the checker
  logic issue_w;
  logic tmr_done;
  logic step_last;
  logic load_last;
  logic writing;

  assign writing   = (st == ST_STAGE) || (st == ST_COMMIT) || (st == ST_RETIRE);
  assign issue_w   = writing && !wait_q;
  assign load_last = (int'(idx) > 2) && (int'(idx) == int'(len_q) + 2);

  atw_cycle_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(issue_w),
    .done (tmr_done)
  );

  atw_write_plan #(
    .ADDR_W(ADDR_W), .MAXB(MAXB), .LEN_W(LEN_W), .IDX_W(IDX_W), .BUF_BASE(BUF_BASE)
  ) u_plan (
    .st   (st),
    .idx  (idx),
    .len  (len_q),
    .dst  (addr_q),
    .data (data_q),
    .addr (nvm_addr),
    .wdata(nvm_wdata),
    .last (step_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_PEEK;
      idx    <= '0;
      len_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      at_q   <= 1'b0;
      wait_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (pwr_fail) begin
      st     <= ST_DEAD;
      wait_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        ST_PEEK: begin
          idx <= '0;
          if (nvm_rdata == MARK_SET) begin
            st   <= ST_LOAD;
            at_q <= 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_LOAD: begin
          idx <= idx + 1'b1;
          case (int'(idx))
            0:       len_q <= nvm_rdata[LEN_W-1:0];
            1:       addr_q[7:0] <= nvm_rdata;
            2:       addr_q[ADDR_W-1:8] <= nvm_rdata[ADDR_W-9:0];
            default: data_q[(int'(idx) - 3)*8 +: 8] <= nvm_rdata;
          endcase
          if (load_last) begin
            st  <= ST_COMMIT;
            idx <= '0;
          end
        end
        ST_IDLE: begin
          if (req_valid) begin
            if (!len_ok(int'(req_len), at_enable, AT_MAXB, MAXB)) begin
              err_q <= 1'b1;
            end else begin
              len_q  <= req_len;
              addr_q <= req_addr;
              data_q <= req_data;
              at_q   <= at_enable;
              idx    <= '0;
              st     <= at_enable ? ST_STAGE : ST_COMMIT;
            end
          end
        end
        ST_STAGE, ST_COMMIT, ST_RETIRE: begin
          if (!wait_q) begin
            wait_q <= 1'b1;
          end else if (tmr_done) begin
            wait_q <= 1'b0;
            if (!step_last) begin
              idx <= idx + 1'b1;
            end else begin
              idx <= '0;
              if (st == ST_STAGE)       st <= ST_COMMIT;
              else if (st == ST_COMMIT) st <= at_q ? ST_RETIRE : ST_IDLE;
              else                      st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_DEAD;
      endcase
    end
  end

  assign nvm_we  = issue_w && !pwr_fail;
  assign busy    = (st != ST_IDLE);
  assign req_err = err_q;

endmodule

// File: rtl/atw_chk.sv
module atw_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_fail,
  input logic busy,
  input logic req_err,
  input logic nvm_we,
  input logic issue_w
);
  // R3: no write strobe while idle
  p_idle_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !nvm_we);

  // R3: an issue cycle is always followed by a wait cycle
  p_issue_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_w |=> !issue_w);

  // R7: supply loss gates the strobe in its own cycle
  p_pf_suppresses_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> !nvm_we);

  // R7: after supply loss the block reports busy
  p_pf_keeps_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> busy);

  // R5: a rejected request starts nothing
  p_reject_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (!busy && !nvm_we));

  // R6: a rejection can only come from an idle cycle
  p_reject_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(!busy));
endmodule

bind tear_guard_writer atw_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwr_fail(pwr_fail),
  .busy    (busy),
  .req_err (req_err),
  .nvm_we  (nvm_we),
  .issue_w (issue_w)
);

// File: tb/tear_guard_writer_tb.sv
module tear_guard_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 4;
  localparam int AW   = 10;
  localparam int MAXB = 16;
  localparam int ATMX = 8;
  localparam int BUFB = 1008;
  localparam int LW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0;
  logic at_enable = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [MAXB*8-1:0] req_data = '0;
  logic busy, req_err, nvm_we;
  logic [AW-1:0] nvm_addr;
  logic [7:0] nvm_wdata, nvm_rdata;

  logic [7:0] mem [0:(1<<AW)-1];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign nvm_rdata = mem[nvm_addr];
  always @(posedge clk) if (nvm_we) mem[nvm_addr] <= nvm_wdata;

  tear_guard_writer #(
    .ADDR_W(AW), .MAXB(MAXB), .AT_MAXB(ATMX), .WR_CYCLES(W), .BUF_BASE(BUFB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .at_enable(at_enable),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
    .busy(busy), .req_err(req_err), .nvm_we(nvm_we), .nvm_addr(nvm_addr),
    .nvm_wdata(nvm_wdata), .nvm_rdata(nvm_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [AW+7:0] exp_q [$];
  int rd_left = 0, busy_left = 0, n_total = 0;
  bit dead = 0, in_rst = 1, exp_err = 0;
  string cur_req = "R1";
  logic [7:0] saved [0:15];

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(seed + i * 13);
  endfunction

  task automatic model_accept();
    int lim, len, a;
    if (req_valid && !dead && !in_rst && rd_left == 0 && busy_left == 0) begin
      lim = at_enable ? ATMX : MAXB;
      len = int'(req_len);
      a   = int'(req_addr);
      if (len == 0 || len > lim) begin
        exp_err = 1;
      end else begin
        exp_q.delete();
        if (at_enable) begin
          for (int i = 0; i < len; i++) exp_q.push_back({AW'(BUFB + 4 + i), req_data[i*8 +: 8]});
          exp_q.push_back({AW'(BUFB + 1), 8'(len)});
          exp_q.push_back({AW'(BUFB + 2), 8'(a)});
          exp_q.push_back({AW'(BUFB + 3), 8'(a >> 8)});
          exp_q.push_back({AW'(BUFB), 8'hA5});
        end
        for (int i = 0; i < len; i++) exp_q.push_back({AW'(a + i), req_data[i*8 +: 8]});
        if (at_enable) exp_q.push_back({AW'(BUFB), 8'h00});
        n_total   = exp_q.size() * (W + 1);
        busy_left = n_total;
      end
    end
  endtask

  task automatic tick();
    bit eb, ew;
    logic [AW+7:0] e;
    @(posedge clk);
    if (pwr_fail) begin
      dead = 1; exp_q.delete(); busy_left = 0; rd_left = 0;
    end
    exp_err = 0;
    model_accept();
    #(CLK_PERIOD/4);
    if (in_rst) begin
      check(nvm_we == 1'b0, "R1 write during reset", nvm_we, 0);
      return;
    end
    if (dead) begin
      check(nvm_we == 1'b0, "R7 write after power loss", nvm_we, 0);
      check(busy == 1'b1, "R7 busy after power loss", busy, 1);
      return;
    end
    if (rd_left > 0) begin
      eb = 1; ew = 0; rd_left--;
    end else if (busy_left > 0) begin
      eb = 1; ew = ((n_total - busy_left) % (W + 1)) == 0; busy_left--;
    end else begin
      eb = 0; ew = 0;
    end
    check(busy == eb, {cur_req, " busy"}, busy, eb);
    check(nvm_we == ew, {cur_req, " write strobe"}, nvm_we, ew);
    if (ew && nvm_we && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check({nvm_addr, nvm_wdata} == e, {cur_req, " write addr/data"}, {nvm_addr, nvm_wdata}, e);
    end
    check(req_err == exp_err, {cur_req, " error pulse"}, req_err, exp_err);
  endtask

  task automatic power_up();
    int len, a;
    in_rst = 1; rst_n = 0; pwr_fail = 0;
    repeat (3) tick();
    dead = 0;
    exp_q.delete(); rd_left = 0; busy_left = 0;
    if (mem[BUFB] == 8'hA5) begin
      len = int'(mem[BUFB + 1]);
      a   = {mem[BUFB + 3], mem[BUFB + 2]};
      for (int i = 0; i < len; i++) exp_q.push_back({AW'(a + i), mem[BUFB + 4 + i]});
      exp_q.push_back({AW'(BUFB), 8'h00});
      rd_left   = 3 + len;
      n_total   = (len + 1) * (W + 1);
      busy_left = n_total;
    end
    rst_n = 1; in_rst = 0;
  endtask

  task automatic issue(input bit at, input int a, input int len, input int seed);
    at_enable = at;
    req_addr  = AW'(a);
    req_len   = LW'(len);
    for (int i = 0; i < MAXB; i++) req_data[i*8 +: 8] = pat(seed, i);
    req_valid = 1;
    tick();
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (rd_left > 0 || busy_left > 0) tick();
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog R3: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'(i * 7 + 3);
    mem[BUFB] = 8'h00;

    // R1: clean record, idle right after reset
    cur_req = "R1";
    power_up();
    tick();
    check(busy == 1'b0, "R1 idle after clean reset", busy, 0);

    // R4: plain write, 5 bytes, neighbour untouched
    cur_req = "R4";
    saved[0] = mem[16 + 5];
    issue(0, 16, 5, 40);
    wait_idle();
    for (int i = 0; i < 5; i++) check(mem[16 + i] == pat(40, i), "R4 dest byte", mem[16 + i], pat(40, i));
    check(mem[16 + 5] == saved[0], "R4 neighbour", mem[21], saved[0]);
    // R4: full page of MAXB bytes
    issue(0, 64, MAXB, 90);
    wait_idle();
    for (int i = 0; i < MAXB; i++) check(mem[64 + i] == pat(90, i), "R4 page byte", mem[64 + i], pat(90, i));

    // R2 / R3: protected write of 8 bytes, upper address byte nonzero
    cur_req = "R2";
    issue(1, 'h123, 8, 7);
    wait_idle();
    for (int i = 0; i < 8; i++) check(mem['h123 + i] == pat(7, i), "R2 dest byte", mem['h123 + i], pat(7, i));
    check(mem[BUFB] == 8'h00, "R2 marker cleared", mem[BUFB], 0);
    check(mem[BUFB + 1] == 8'd8, "R2 count in record", mem[BUFB + 1], 8);
    cur_req = "R3";
    issue(1, 'h2F0, 1, 200);
    wait_idle();
    check(mem['h2F0] == pat(200, 0), "R3 single byte", mem['h2F0], pat(200, 0));

    // R5: rejected lengths
    cur_req = "R5";
    saved[1] = mem['h180];
    issue(1, 'h180, 9, 1);
    tick(); tick();
    issue(0, 'h180, 0, 1);
    tick();
    issue(0, 'h180, MAXB + 1, 1);
    tick();
    check(mem['h180] == saved[1], "R5 nothing written", mem['h180], saved[1]);
    check(busy == 1'b0, "R5 stays idle", busy, 0);

    // R6: request while busy is ignored
    cur_req = "R6";
    saved[2] = mem['h300];
    issue(1, 'h200, 3, 55);
    repeat (3) tick();
    issue(0, 'h300, 2, 77);
    wait_idle();
    check(mem['h300] == saved[2], "R6 ignored request", mem['h300], saved[2]);
    check(mem['h200] == pat(55, 0), "R6 first request done", mem['h200], pat(55, 0));

    // R7 / R8 / R9: cut power at every cycle of a protected write
    for (int k = 0; k <= 86; k++) begin
      int done_w;
      bit want_new;
      for (int i = 0; i < 6; i++) mem['h080 + i] = pat(300, i);
      cur_req = "R9";
      issue(1, 'h080, 6, k);
      repeat (k) tick();
      cur_req = "R7";
      pwr_fail = 1;
      tick();
      tick();
      cur_req = "R8";
      power_up();
      wait_idle();
      done_w   = (k + W) / (W + 1);
      want_new = (done_w >= 10);
      for (int i = 0; i < 6; i++) begin
        logic [7:0] ev;
        ev = want_new ? pat(k, i) : pat(300, i);
        check(mem['h080 + i] == ev, "R9 dest after restart", mem['h080 + i], ev);
      end
      check(mem[BUFB] == 8'h00, "R8 marker cleared after restart", mem[BUFB], 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule